// File: doc/BRIEF.md
# Compatibility-Mode Parallel Byte Sender

This block is the host end of a one-way, byte-wide parallel link to a printer-style peripheral. A producer hands it one byte at a time on a valid/ready stream input. The block puts the byte on eight data lines and waits out a setup interval. It then waits while the peripheral reports busy, pulses an active-low strobe, and waits for the peripheral's active-low acknowledge pulse. Only after that handshake is complete does it take the next byte.

Setup, strobe width, hold and acknowledge timeout are all set in clock cycles by parameters. The defaults assume a 100 MHz clock: 0.5 µs setup, 1 µs strobe, 0.5 µs hold and a 20 µs acknowledge timeout. A transfer therefore costs about 2 µs plus the peripheral's own response time, which supports rates well above 50 KB/s. Busy and acknowledge are asynchronous to the clock and pass through two-flop synchronizers. The end of acknowledge is detected on its rising edge. If that edge never arrives, a sticky timeout flag is raised and the block goes back to idle.

Back-pressure rules: `in_ready` is high only while the block is idle. A byte transfers on any rising clock edge at which both `in_valid` and `in_ready` are high. The producer may hold `in_valid` high and change `in_data` freely while `in_ready` is low. Nothing it presents during that time has any effect.

Top module: `par_byte_sender`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released, `in_ready`=1, `stb_n_o`=1, `ack_timeout_o`=0 and `pd_o`=0.
- R2: A byte accepted at a clock edge (with `in_valid`=1 and `in_ready`=1) appears on `pd_o` right after that edge. It stays on `pd_o` unchanged until the next byte is accepted.
- R3: `stb_n_o` goes low only after the new byte has been on `pd_o` for at least SETUP_CYC cycles. It also requires that the synchronized busy input was low at that edge. While busy stays high, the strobe stays high and the byte is held.
- R4: Each strobe pulse is low for exactly STROBE_CYC consecutive cycles.
- R5: `in_ready` is low from acceptance until the handshake ends. After the strobe rises, at least HOLD_CYC+1 cycles pass before `in_ready` returns high. Input presented while `in_ready` is low is ignored, and `pd_o` keeps the current byte.
- R6: After the hold interval, the transfer completes one cycle after a synchronized rising edge of `ack_n_i` has been seen. An edge that arrives while the strobe is low or during the hold interval counts.
- R7: If no acknowledge rising edge is seen within TIMEOUT_CYC cycles after the hold interval, `ack_timeout_o` is set and the block returns to idle. The flag stays set through later transfers until reset.
- R8: `busy_i` and `ack_n_i` each pass through two flops. A change on either pin therefore affects the decision at the third clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer has a byte |
| in_ready | output | 1 | Block is idle and takes a byte |
| in_data | input | DW | Byte from the producer |
| pd_o | output | DW | Parallel data lines to the peripheral |
| stb_n_o | output | 1 | Data strobe, active low |
| busy_i | input | 1 | Peripheral busy, active high, asynchronous |
| ack_n_i | input | 1 | Peripheral acknowledge, active low, asynchronous |
| ack_timeout_o | output | 1 | Sticky acknowledge-timeout flag |

## Verification
The bench builds the block with SETUP_CYC=3, STROBE_CYC=4, HOLD_CYC=2 and TIMEOUT_CYC=20. With these values every phase lasts several cycles but stays short, so the per-cycle reference model can follow the whole handshake edge by edge. The short timeout makes a missing acknowledge, and the sticky flag that follows, cheap to provoke. It also lets a busy stall outlast the setup interval. A peripheral responder in the bench acknowledges late, early (during the strobe) or never. This places the acknowledge edge in the strobe, hold and wait phases.

// File: rtl/ptx_pkg.sv
package ptx_pkg;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_WAIT   = 3'd4
  } ptx_phase_e;

  function automatic int unsigned ptx_max4(input int unsigned a, input int unsigned b,
                                           input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/ptx_sync.sv
module ptx_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/ptx_rise.sv
module ptx_rise #(
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic rise
);

  logic last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= RST_VAL;
    else        last_q <= d;
  end

  assign rise = d & ~last_q;

endmodule

// File: rtl/ptx_ctrl.sv
module ptx_ctrl
  import ptx_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SETUP_CYC   = 50,
  parameter int STROBE_CYC  = 100,
  parameter int HOLD_CYC    = 50,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  input  logic          busy_s,
  input  logic          ack_rise,
  output logic [DW-1:0] pd,
  output logic          stb_n,
  output logic          timeout
);

  localparam int unsigned MAXC = ptx_max4(SETUP_CYC, STROBE_CYC, HOLD_CYC, TIMEOUT_CYC);
  localparam int          CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] LD_SETUP  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] LD_STROBE = CW'(STROBE_CYC - 1);
  localparam logic [CW-1:0] LD_HOLD   = CW'(HOLD_CYC - 1);
  localparam logic [CW-1:0] LD_WAIT   = CW'(TIMEOUT_CYC - 1);

  ptx_phase_e    ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] pd_q, pd_d;
  logic          seen_q, seen_d;
  logic          err_q, err_d;
  logic          cnt_zero;
  logic          take;

  assign cnt_zero = (cnt_q == '0);
  assign take     = in_valid && (ph_q == PH_IDLE);

  always_comb begin
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    pd_d   = pd_q;
    seen_d = seen_q;
    err_d  = err_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (take) begin
          ph_d   = PH_SETUP;
          cnt_d  = LD_SETUP;
          pd_d   = in_data;
          seen_d = 1'b0;
        end
      end
      PH_SETUP: begin
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!busy_s) begin
          ph_d  = PH_STROBE;
          cnt_d = LD_STROBE;
        end
      end
      PH_STROBE: begin
        if (ack_rise) seen_d = 1'b1;
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          ph_d  = PH_HOLD;
          cnt_d = LD_HOLD;
        end
      end
      PH_HOLD: begin
        if (ack_rise) seen_d = 1'b1;
        if (!cnt_zero) begin
          cnt_d = cnt_q - 1'b1;
        end else begin
          ph_d  = PH_WAIT;
          cnt_d = LD_WAIT;
        end
      end
      PH_WAIT: begin
        if (ack_rise || seen_q) begin
          ph_d = PH_IDLE;
        end else if (cnt_zero) begin
          ph_d  = PH_IDLE;
          err_d = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      pd_q   <= '0;
      seen_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      pd_q   <= pd_d;
      seen_q <= seen_d;
      err_q  <= err_d;
    end
  end

  assign in_ready = (ph_q == PH_IDLE);
  assign stb_n    = (ph_q != PH_STROBE);
  assign pd       = pd_q;
  assign timeout  = err_q;

endmodule

// File: rtl/par_byte_sender.sv
module par_byte_sender #(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int SETUP_CYC   = 50,
  parameter int STROBE_CYC  = 100,
  parameter int HOLD_CYC    = 50,
  parameter int TIMEOUT_CYC = 2000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic [DW-1:0] pd_o,
  output logic          stb_n_o,
  input  logic          busy_i,
  input  logic          ack_n_i,
  output logic          ack_timeout_o
);

  logic busy_sync;
  logic ack_sync;
  logic ack_rise;

  ptx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b0)) i_busy_sync (
    .clk(clk), .rst_n(rst_n), .d(busy_i), .q(busy_sync)
  );

  ptx_sync #(.W(1), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_ack_sync (
    .clk(clk), .rst_n(rst_n), .d(ack_n_i), .q(ack_sync)
  );

  ptx_rise #(.RST_VAL(1'b1)) i_ack_rise (
    .clk(clk), .rst_n(rst_n), .d(ack_sync), .rise(ack_rise)
  );

  ptx_ctrl #(
    .DW(DW), .SETUP_CYC(SETUP_CYC), .STROBE_CYC(STROBE_CYC),
    .HOLD_CYC(HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .busy_s(busy_sync), .ack_rise(ack_rise),
    .pd(pd_o), .stb_n(stb_n_o), .timeout(ack_timeout_o)
  );

endmodule

// File: rtl/par_byte_sender_chk.sv
module par_byte_sender_chk #(
  parameter int DW         = 8,
  parameter int STROBE_CYC = 100
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [DW-1:0] in_data,
  input logic [DW-1:0] pd_o,
  input logic          stb_n_o,
  input logic          busy_s,
  input logic          ack_timeout_o
);

  int unsigned low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run <= 0;
    else if (!stb_n_o) low_run <= low_run + 1;
    else               low_run <= 0;
  end

  a_r2_accept_to_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (pd_o == $past(in_data)));

  a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !(($past(in_valid) && $past(in_ready))) |-> $stable(pd_o));

  a_r3_no_strobe_on_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_n_o) |-> !$past(busy_s));

  a_r4_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_n_o) |-> (low_run == STROBE_CYC));

  a_r4_strobe_not_long: assert property (@(posedge clk) disable iff (!rst_n)
    low_run <= STROBE_CYC);

  a_r5_busy_when_strobing: assert property (@(posedge clk) disable iff (!rst_n)
    !stb_n_o |-> !in_ready);

  a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ack_timeout_o) |-> ack_timeout_o);

endmodule

bind par_byte_sender par_byte_sender_chk #(.DW(DW), .STROBE_CYC(STROBE_CYC)) i_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .pd_o(pd_o), .stb_n_o(stb_n_o), .busy_s(busy_sync),
  .ack_timeout_o(ack_timeout_o)
);

// File: tb/test_par_byte_sender.sv
`timescale 1ns/1ps
module test_par_byte_sender;

  localparam int DW  = 8;
  localparam int SU  = 3;
  localparam int STB = 4;
  localparam int HLD = 2;
  localparam int TO  = 20;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic [DW-1:0] pd_o;
  logic          stb_n_o;
  logic          busy_i = 1'b0;
  logic          ack_n_i = 1'b1;
  logic          ack_timeout_o;

  int tests = 0;
  int fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  par_byte_sender #(
    .DW(DW), .SYNC_STAGES(2), .SETUP_CYC(SU), .STROBE_CYC(STB),
    .HOLD_CYC(HLD), .TIMEOUT_CYC(TO)
  ) i_par_byte_sender (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .pd_o(pd_o), .stb_n_o(stb_n_o), .busy_i(busy_i),
    .ack_n_i(ack_n_i), .ack_timeout_o(ack_timeout_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: transfer phase as an integer, pin history as shift variables
  int   m_ph = 0;
  int   m_cnt = 0;
  int   m_data = 0;
  bit   m_seen = 0;
  bit   m_err = 0;
  bit   b1 = 0, b2 = 0;
  bit   a1 = 1, a2 = 1, a3 = 1;

  always @(posedge clk or negedge rst_n) begin
    bit rise;
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_data = 0; m_seen = 0; m_err = 0;
      b1 = 0; b2 = 0; a1 = 1; a2 = 1; a3 = 1;
    end else begin
      rise = a2 && !a3;
      case (m_ph)
        0: if (in_valid) begin m_ph = 1; m_cnt = SU - 1; m_data = in_data; m_seen = 0; end
        1: if (m_cnt > 0) m_cnt--; else if (!b2) begin m_ph = 2; m_cnt = STB - 1; end
        2: begin
             if (rise) m_seen = 1;
             if (m_cnt > 0) m_cnt--; else begin m_ph = 3; m_cnt = HLD - 1; end
           end
        3: begin
             if (rise) m_seen = 1;
             if (m_cnt > 0) m_cnt--; else begin m_ph = 4; m_cnt = TO - 1; end
           end
        default: begin
             if (rise || m_seen) m_ph = 0;
             else if (m_cnt == 0) begin m_ph = 0; m_err = 1; end
             else m_cnt--;
           end
      endcase
      a3 = a2; a2 = a1; a1 = ack_n_i;
      b2 = b1; b1 = busy_i;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(in_ready == (m_ph == 0), "R5 R8 ready", in_ready, m_ph == 0);
      check(stb_n_o == (m_ph != 2), "R3 R4 R8 strobe", stb_n_o, m_ph != 2);
      check(pd_o == m_data[DW-1:0], "R2 data", pd_o, m_data);
      check(ack_timeout_o == m_err, "R6 R7 timeout", ack_timeout_o, m_err);
    end
  end

  // Peripheral responder: 0 = ack after strobe, 1 = never, 2 = ack during strobe
  int mode = 0;
  int ack_wait = 0;
  int ack_low = 0;
  bit prev_stb = 1;

  always @(negedge clk) begin
    if (ack_low > 0) begin ack_low--; if (ack_low == 0) ack_n_i = 1'b1; end
    if (ack_wait > 0) begin ack_wait--; if (ack_wait == 0) begin ack_n_i = 1'b0; ack_low = 3; end end
    if (mode == 0 && stb_n_o && !prev_stb) ack_wait = 3;
    if (mode == 2 && !stb_n_o && prev_stb) begin ack_n_i = 1'b0; ack_low = 2; end
    prev_stb = stb_n_o;
  end

  task automatic send(input logic [DW-1:0] d);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!in_ready) @(negedge clk);
  endtask

  task automatic measure(output int w, output int h);
    while (stb_n_o) @(negedge clk);
    w = 0;
    while (!stb_n_o) begin w++; @(negedge clk); end
    h = 0;
    while (!in_ready) begin h++; @(negedge clk); end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int w, h;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    check(stb_n_o == 1'b1, "R1 strobe", stb_n_o, 1);
    check(ack_timeout_o == 1'b0, "R1 timeout", ack_timeout_o, 0);
    check(pd_o == '0, "R1 data", pd_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready && stb_n_o && !ack_timeout_o, "R1 after release", in_ready, 1);

    // Normal transfer, late acknowledge
    mode = 0;
    send(8'hA5);
    check(pd_o == 8'hA5, "R2 byte on lines", pd_o, 8'hA5);
    check(in_ready == 1'b0, "R5 busy during transfer", in_ready, 0);
    measure(w, h);
    check(w == STB, "R4 strobe width", w, STB);
    check(h >= HLD + 1, "R5 hold before ready", h, HLD + 1);
    check(ack_timeout_o == 1'b0, "R6 no timeout", ack_timeout_o, 0);

    // Busy stall during setup
    @(negedge clk);
    busy_i = 1'b1;
    send(8'h3C);
    repeat (10) @(negedge clk);
    check(stb_n_o == 1'b1, "R3 strobe held while busy", stb_n_o, 1);
    check(pd_o == 8'h3C, "R3 byte held while busy", pd_o, 8'h3C);
    busy_i = 1'b0;
    measure(w, h);
    check(w == STB, "R4 strobe width after stall", w, STB);
    wait_idle();

    // Early acknowledge during strobe
    mode = 2;
    send(8'h0F);
    measure(w, h);
    check(h == HLD + 1, "R6 early ack completes after hold", h, HLD + 1);
    check(ack_timeout_o == 1'b0, "R6 early ack no timeout", ack_timeout_o, 0);

    // Input ignored while not ready
    mode = 0;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 8'h11;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_data = 8'h22;
    repeat (5) @(negedge clk);
    check(pd_o == 8'h11, "R5 input ignored while busy", pd_o, 8'h11);
    wait_idle();
    @(negedge clk);
    in_valid = 1'b0;
    check(pd_o == 8'h22, "R2 held byte taken when idle", pd_o, 8'h22);
    wait_idle();

    // Missing acknowledge
    mode = 1;
    send(8'h5A);
    wait_idle();
    check(ack_timeout_o == 1'b1, "R7 timeout raised", ack_timeout_o, 1);
    mode = 0;
    send(8'hC3);
    wait_idle();
    check(ack_timeout_o == 1'b1, "R7 timeout sticky", ack_timeout_o, 1);
    check(pd_o == 8'hC3, "R2 transfer after timeout", pd_o, 8'hC3);

    repeat (5) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule